// File: doc/BRIEF.md
# Windowed Telemetry Block Averager

This block turns a stream of decimated 12-bit readings from three voltage-sense channels into slow telemetry values. One free-running window timer is shared by all channels, so their windows stay aligned. While a window is open, each channel adds up every reading that its valid strobe qualifies and counts how many arrived. When the window closes, the sum and the count are handed to a per-channel sequential divider. The running totals restart at once for the next window.

When the division completes, the channel's result register takes the new average and a one-cycle update pulse marks the change. Between updates the result is frozen. A host that reads at least once per window therefore always sees the complete average of one whole window, never a partial one. Results are read through a small address-decoded port. Channel 1 sits at 0x15, channel 2 at 0x16 and channel 3 at 0x17. With a 125 MHz clock, the default window of 1,250,000 cycles is 10 ms. The window must be longer than the divider latency of SUM_W + 1 cycles.

Top module: `tlm_window_avg`

## Requirements
- R1: Each of the three channels accepts a 12-bit reading on any cycle where its valid bit is high, and every such reading counts in its window. Channel c uses `smp_vld[c]` and `smp_data[12*c +: 12]`.
- R2: All channels share one window of WIN_CYCLES clock cycles. The windows follow each other with no gap, starting at the first clock edge after the internal reset release.
- R3: A window holding up to MAX_SAMPLES full-scale readings (4095) is averaged with no loss from overflow.
- R4: The published value is the window sum divided by the window's sample count, with the fraction truncated.
- R5: The result register and its update pulse change on the clock edge that comes SUM_W edges after the edge closing the window. SUM_W = 12 + clog2(MAX_SAMPLES+1). The pulse lasts one cycle.
- R6: Outside that edge, a result register holds its value, and its update pulse stays low.
- R7: A window with no readings on a channel leaves that channel's result unchanged and produces no update pulse.
- R8: During reset, and until the first average is published, every result reads zero and every update pulse is low.
- R9: The read port is combinational. `rd_addr` 0x15, 0x16 and 0x17 return the results of channels 1, 2 and 3 (index 0, 1, 2). Any other address returns zero.
- R10: A reading in the last cycle of a window counts in that window. A reading in the next cycle counts in the following window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 3 | Per-channel reading strobe |
| smp_data | input | 36 | Per-channel 12-bit readings, channel c in bits 12c+11..12c |
| rd_addr | input | 8 | Result register address |
| rd_data | output | 12 | Addressed result value |
| upd | output | 3 | Per-channel one-cycle update pulse |

## Verification
The hardest cases to produce from the ports are a reading on exactly the closing cycle of a window, and a channel that stays silent for a whole window while its neighbours keep publishing. Both must line up with a timer that is not visible from outside. The bench counts cycles from the internal reset release. It drives a fixed schedule of patterns per window and channel: every cycle at full scale, sparse strides, a single reading on the closing cycle, a single reading on the opening cycle, and empty windows. In every cycle it predicts the exact cycle of the update pulse and the value each address should return.

// File: rtl/tlm_avg_pkg.sv
package tlm_avg_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  function automatic int sum_width(input int smp_w, input int max_smp);
    return smp_w + $clog2(max_smp + 1);
  endfunction

  function automatic int cnt_width(input int max_smp);
    return $clog2(max_smp + 1);
  endfunction

endpackage

// File: rtl/tlm_win_timer.sv
module tlm_win_timer #(
  parameter int WIN_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);

  localparam int TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign win_end = (cnt_q == LAST);

  AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end); // R2

endmodule

// File: rtl/tlm_chan_accum.sv
module tlm_chan_accum #(
  parameter int SMP_W       = 12,
  parameter int MAX_SAMPLES = 16384,
  parameter int SUM_W       = 27,
  parameter int CNT_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  output logic [SUM_W-1:0] tot_sum,
  output logic [CNT_W-1:0] tot_cnt
);

  logic [SUM_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] num_q, num_d;
  logic [SUM_W-1:0] addend;

  assign addend  = smp_vld ? {{(SUM_W-SMP_W){1'b0}}, smp_data} : '0;
  assign tot_sum = acc_q + addend;
  assign tot_cnt = num_q + CNT_W'(smp_vld);

  always_comb begin
    if (win_end) begin
      acc_d = '0;
      num_d = '0;
    end else begin
      acc_d = tot_sum;
      num_d = tot_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      num_q <= '0;
    end else begin
      acc_q <= acc_d;
      num_q <= num_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> (num_q < CNT_W'(MAX_SAMPLES))); // R3

endmodule

// File: rtl/tlm_seq_div.sv
module tlm_seq_div
  import tlm_avg_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int SUM_W = 27,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SUM_W-1:0] dividend,
  input  logic [CNT_W-1:0] divisor,
  output logic [SMP_W-1:0] res,
  output logic             upd
);

  localparam int IW = $clog2(SUM_W);

  div_state_e       st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [SUM_W-1:0] quo_q, quo_d;
  logic [CNT_W-1:0] dvs_q, dvs_d;
  logic [SMP_W-1:0] res_q, res_d;
  logic             upd_q, upd_d;

  logic [CNT_W:0]   trial;
  logic             ge;
  logic [CNT_W-1:0] rem_step;
  logic [SUM_W-1:0] quo_step;
  logic [CNT_W:0]   diff;

  assign trial    = {rem_q, quo_q[SUM_W-1]};
  assign ge       = (trial >= {1'b0, dvs_q});
  assign diff     = trial - {1'b0, dvs_q};
  assign rem_step = ge ? diff[CNT_W-1:0] : trial[CNT_W-1:0];
  assign quo_step = {quo_q[SUM_W-2:0], ge};

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    res_d = res_q;
    upd_d = 1'b0;
    if (start) begin
      st_d  = DIV_RUN;
      idx_d = IW'(SUM_W - 1);
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
    end else if (st_q == DIV_RUN) begin
      rem_d = rem_step;
      quo_d = quo_step;
      if (idx_q == '0) begin
        st_d  = DIV_IDLE;
        res_d = quo_step[SMP_W-1:0];
        upd_d = 1'b1;
      end else begin
        idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DIV_IDLE;
      idx_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      res_q <= '0;
      upd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      res_q <= res_d;
      upd_q <= upd_d;
    end
  end

  assign res = res_q;
  assign upd = upd_q;

  AST_DIV_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == DIV_IDLE)); // R5

  AST_QUOT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DIV_RUN && idx_q == '0 && !start) |-> (quo_step[SUM_W-1:SMP_W] == '0)); // R4

  AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(res_q)); // R6

  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q); // R5

endmodule

// File: rtl/tlm_window_avg.sv
module tlm_window_avg
  import tlm_avg_pkg::*;
#(
  parameter int          NUM_CH      = 3,
  parameter int          SMP_W       = 12,
  parameter int          WIN_CYCLES  = 1250000,
  parameter int          MAX_SAMPLES = 16384,
  parameter int          ADDR_W      = 8,
  parameter int          BASE_ADDR   = 'h15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       smp_vld,
  input  logic [NUM_CH*SMP_W-1:0] smp_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [SMP_W-1:0]        rd_data,
  output logic [NUM_CH-1:0]       upd
);

  localparam int SUM_W = sum_width(SMP_W, MAX_SAMPLES);
  localparam int CNT_W = cnt_width(MAX_SAMPLES);

  logic rs1_q, rs2_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign rst_int_n = rs2_q;

  logic win_end;

  tlm_win_timer #(
    .WIN_CYCLES(WIN_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .win_end(win_end)
  );

  logic [SMP_W-1:0] res [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SUM_W-1:0] tot_sum;
    logic [CNT_W-1:0] tot_cnt;
    logic             div_go;

    tlm_chan_accum #(
      .SMP_W      (SMP_W),
      .MAX_SAMPLES(MAX_SAMPLES),
      .SUM_W      (SUM_W),
      .CNT_W      (CNT_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .win_end (win_end),
      .smp_vld (smp_vld[c]),
      .smp_data(smp_data[c*SMP_W +: SMP_W]),
      .tot_sum (tot_sum),
      .tot_cnt (tot_cnt)
    );

    assign div_go = win_end && (tot_cnt != '0);

    tlm_seq_div #(
      .SMP_W(SMP_W),
      .SUM_W(SUM_W),
      .CNT_W(CNT_W)
    ) u_div (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .start   (div_go),
      .dividend(tot_sum),
      .divisor (tot_cnt),
      .res     (res[c]),
      .upd     (upd[c])
    );

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
      (win_end && tot_cnt == '0) |=> !upd[c]); // R7
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(BASE_ADDR + c)) rd_data = res[c];
    end
  end

endmodule

// File: tb/tlm_window_avg_bench.sv
module tlm_window_avg_bench;

  localparam int NCH   = 3;
  localparam int SW    = 12;
  localparam int WIN   = 80;
  localparam int MAXS  = 80;
  localparam int SUMW  = SW + $clog2(MAXS + 1);
  localparam int NWIN  = 8;
  localparam int TOTAL = NWIN * WIN + 2 * WIN;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    smp_vld;
  logic [NCH*SW-1:0] smp_data;
  logic [7:0]        rd_addr;
  logic [SW-1:0]     rd_data;
  logic [NCH-1:0]    upd;

  always #4 clk = ~clk;

  tlm_window_avg #(
    .NUM_CH     (NCH),
    .SMP_W      (SW),
    .WIN_CYCLES (WIN),
    .MAX_SAMPLES(MAXS),
    .ADDR_W     (8),
    .BASE_ADDR  ('h15)
  ) u_tlm_window_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .smp_data(smp_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .upd     (upd)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Pattern schedule per window w, channel ch, in-window cycle i.
  // R3: full-scale every cycle; R10: single reading on the closing cycle;
  // R7: empty windows; R1: sparse strides that must all be counted.
  function automatic bit pat_vld(input int w, input int ch, input int i);
    case (w % 6)
      0: return (ch == 0) ? 1'b1 : (ch == 1) ? (i % 3 == 0) : 1'b0;
      1: return (ch == 0) ? (i == WIN - 1) : (ch == 1) ? 1'b1 : (i == 0);
      2: return (ch == 0) ? 1'b0 : (ch == 1) ? (i % 2 == 1) : 1'b1;
      3: return ((i * 7 + ch) % 5 == 0);
      4: return (ch == 2) ? (i == WIN - 1 || i == 0) : (i % 11 == ch);
      default: return (ch != 1) && (i % 4 != 3);
    endcase
  endfunction

  function automatic int pat_val(input int w, input int ch, input int i);
    if ((w == 0 && ch == 0) || (w == 2 && ch == 2)) return 4095;
    if (w == 1 && ch == 2) return 0;
    return (w * 517 + ch * 1301 + i * 37 + (i * i) % 97) % 4096;
  endfunction

  function automatic int addr_of(input int t);
    case (t % 6)
      0: return 'h14;
      1: return 'h15;
      2: return 'h16;
      3: return 'h17;
      4: return 'h18;
      default: return 'hFF;
    endcase
  endfunction

  int exp_val [NCH];
  int sum_a   [NCH];
  int cnt_a   [NCH];
  int pend_v  [NCH];
  bit pend_h  [NCH];
  bit any_pub;

  initial begin
    rst_n    = 1'b0;
    smp_vld  = '0;
    smp_data = '0;
    rd_addr  = '0;
    any_pub  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      exp_val[c] = 0; sum_a[c] = 0; cnt_a[c] = 0; pend_v[c] = 0; pend_h[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int a = 'h14; a <= 'h18; a++) begin
      rd_addr = 8'(a);
      #1;
      check("R8 reset read", int'(rd_data), 0);
    end
    check("R8 reset upd", int'(upd), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < TOTAL; t++) begin
      bit [NCH-1:0] exp_upd;
      int w;
      int i;
      int ea;
      int er;
      exp_upd = '0;
      if (t > 0 && t % WIN == 0) begin
        for (int c = 0; c < NCH; c++) begin
          pend_h[c] = (cnt_a[c] > 0);
          pend_v[c] = (cnt_a[c] > 0) ? sum_a[c] / cnt_a[c] : 0; // R4 truncating
          sum_a[c] = 0;
          cnt_a[c] = 0;
        end
      end
      if (t >= WIN && t % WIN == SUMW) begin
        for (int c = 0; c < NCH; c++) begin
          if (pend_h[c]) begin
            exp_upd[c] = 1'b1;
            exp_val[c] = pend_v[c];
            any_pub    = 1'b1;
          end
        end
      end
      ea = addr_of(t);
      rd_addr = 8'(ea);
      #1;
      for (int c = 0; c < NCH; c++) begin
        if (exp_upd[c])
          check("R5 update pulse timing", int'(upd[c]), 1);
        else if (t >= WIN && t % WIN == SUMW)
          check("R7 empty window no pulse", int'(upd[c]), 0);
        else
          check("R6 no pulse between updates", int'(upd[c]), 0);
      end
      er = (ea >= 'h15 && ea <= 'h17) ? exp_val[ea - 'h15] : 0;
      if (!(ea >= 'h15 && ea <= 'h17))
        check("R9 unmapped address", int'(rd_data), er);
      else if (!any_pub)
        check("R8 zero before first result", int'(rd_data), er);
      else
        check("R4 R1 R2 R10 published average", int'(rd_data), er);
      w = t / WIN;
      i = t % WIN;
      for (int c = 0; c < NCH; c++) begin
        bit v;
        int d;
        v = (w < NWIN) && pat_vld(w, c, i);
        d = pat_val(w, c, i);
        smp_vld[c] = v;
        smp_data[c*SW +: SW] = SW'(d);
        if (v) begin
          sum_a[c] += d;
          cnt_a[c] += 1;
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    smp_vld = '0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule